// File: doc/BRIEF.md
# Programmable Clock Divider with Inversion

This block derives a slower clock from a reference clock. The divide ratio is any integer from 1 to 32. A single configuration byte sets it. The byte carries three controls: an enable bit, a 5-bit ratio code and an output polarity bit. The ratio code is offset by one, so the value zero selects the undivided reference. When the enable bit is clear, the reference is also passed straight through. The polarity bit complements whatever the divider produces.

The core is a small state machine clocked by the reference. It has four states:

- `ST_START` is the state after reset. The divided level is low.
- `ST_BYPASS` is the pass-through mode.
- `ST_HIGH` is the high phase of a divided period.
- `ST_LOW` is the low phase of a divided period.

The transitions are named as follows:

- **load**: from `ST_START` or `ST_BYPASS`, the machine goes to `ST_HIGH` when the byte requests division, and to `ST_BYPASS` otherwise.
- **half**: `ST_HIGH` goes to `ST_LOW` after floor(R/2) cycles.
- **wrap**: at the end of `ST_LOW`, the machine either starts a new period in `ST_HIGH` or returns to `ST_BYPASS`.

The ratio and mode are sampled only at a **load** or a **wrap**. As a result, a change to the byte never cuts a period short. The polarity bit acts at once on the output.

Top module: `clkdiv_prog`

## Requirements
- R1: The configuration byte is decoded as follows: bit 0 is the divider enable, bits 5:1 are the ratio code, and bit 6 is output inversion.
- R2: With the enable bit set and ratio code N in the range 1 to 31, the output is periodic with a period of N+1 reference cycles.
- R3: With the enable bit set and ratio code 0, the output follows the reference clock level.
- R4: With the enable bit clear, the output follows the reference clock level, whatever the ratio code.
- R5: With bit 6 set, the output is the complement of the level it would have with bit 6 clear. This holds in both divided and pass-through modes, and the bit acts without waiting for a period boundary.
- R6: For a ratio R of 2 or more, each period is high for floor(R/2) reference cycles and then low for the remaining cycles. The high phase starts at the rising reference edge that begins the period.
- R7: A new ratio code or enable value that arrives during a divided period takes effect only at the rising edge that ends the current low phase. The period in progress completes at the old ratio.
- R8: While reset is asserted, the divided level is low, so the output equals bit 6. The first rising reference edge after reset is released loads the byte.
- R9: Bit 7 of the byte has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Configuration byte: enable, ratio code, inversion, unused top bit |
| clk_out | output | 1 | Divided, bypassed and/or inverted clock |

## Verification
The bench builds the block with the default 5-bit ratio code. This makes the whole code range reachable, including the smallest divided ratio (2), the largest (32), odd and even ratios, and code 0. A scoreboard model predicts the output level in both halves of every reference cycle. This lets pass-through modes, phase lengths, mid-period reconfiguration and immediate inversion all be compared cycle by cycle.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_BYPASS = 2'd1,
        ST_HIGH   = 2'd2,
        ST_LOW    = 2'd3
    } div_state_e;

endpackage

// File: rtl/clkdiv_cfg_decode.sv
`timescale 1ns/1ps
module clkdiv_cfg_decode #(
    parameter int CODE_W = 5,
    localparam int CFG_W   = CODE_W + 3,
    localparam int RATIO_W = CODE_W + 1
) (
    input  logic [CFG_W-1:0]   cfg_byte,
    output logic               divide_req,
    output logic [RATIO_W-1:0] ratio_req,
    output logic               invert
);
    // Field positions (R1): enable at bit 0, code just above, invert above the code.
    localparam int EN_BIT   = 0;
    localparam int CODE_LSB = 1;
    localparam int INV_BIT  = CODE_W + 1;

    logic              en_bit;
    logic [CODE_W-1:0] code;

    always_comb begin
        en_bit     = cfg_byte[EN_BIT];
        code       = cfg_byte[CODE_LSB +: CODE_W];
        invert     = cfg_byte[INV_BIT];
        // Code 0 or a clear enable both mean pass-through (R3, R4).
        divide_req = en_bit && (code != '0);
        ratio_req  = {1'b0, code} + RATIO_W'(1);
    end
endmodule

// File: rtl/clkdiv_phase_fsm.sv
`timescale 1ns/1ps
module clkdiv_phase_fsm
    import clkdiv_pkg::*;
#(
    parameter int CODE_W = 5,
    localparam int RATIO_W = CODE_W + 1
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               divide_req,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic               div_level,
    output logic               bypass_sel
);
    div_state_e          state_q, state_d;
    logic [CODE_W-1:0]   cnt_q, cnt_d;
    logic [RATIO_W-1:0]  ratio_q, ratio_d;
    logic [RATIO_W-1:0]  cnt_ext;
    logic [RATIO_W-1:0]  half_m1;
    logic [RATIO_W-1:0]  last_m1;
    logic                at_last;

    always_comb begin
        cnt_ext = {1'b0, cnt_q};
        half_m1 = (ratio_q >> 1) - RATIO_W'(1);
        last_m1 = ratio_q - RATIO_W'(1);
        at_last = (state_q == ST_LOW) && (cnt_ext == last_m1);
    end

    // Next-state logic: transitions load, half, wrap
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        unique case (state_q)
            ST_START, ST_BYPASS: begin
                if (divide_req) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    ratio_d = ratio_req;
                end else begin
                    state_d = ST_BYPASS;
                end
            end
            ST_HIGH: begin
                cnt_d = cnt_q + CODE_W'(1);
                if (cnt_ext == half_m1) begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (at_last) begin
                    if (divide_req) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                        ratio_d = ratio_req;
                    end else begin
                        state_d = ST_BYPASS;
                        cnt_d   = '0;
                    end
                end else begin
                    cnt_d = cnt_q + CODE_W'(1);
                end
            end
            default: state_d = ST_START;
        endcase
    end

    // State register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            ratio_q <= RATIO_W'(2);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
        end
    end

    // Outputs
    always_comb begin
        div_level  = (state_q == ST_HIGH);
        bypass_sel = (state_q == ST_BYPASS);
    end

    // Counter never leaves the period (R2)
    assert_cnt_bound_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_HIGH || state_q == ST_LOW) |-> (cnt_ext < ratio_q));

    // Ratio held for the whole period (R7)
    assert_ratio_hold_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((state_q == ST_HIGH || state_q == ST_LOW) && !at_last) |=> $stable(ratio_q));

    // High phase lasts floor(R/2) cycles (R6)
    assert_high_len_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($fell(div_level) && state_q == ST_LOW) |-> ($past(cnt_ext) == ($past(ratio_q) >> 1) - RATIO_W'(1)));

    // Wrap with division requested restarts a period at the new ratio (R7)
    assert_wrap_reload_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (at_last && divide_req) |=> (state_q == ST_HIGH && cnt_q == '0 && ratio_q == $past(ratio_req)));
endmodule

// File: rtl/clkdiv_out_mux.sv
`timescale 1ns/1ps
module clkdiv_out_mux (
    input  logic clk_ref,
    input  logic div_level,
    input  logic bypass_sel,
    input  logic invert,
    output logic clk_out
);
    logic pre_inv;

    always_comb begin
        pre_inv = bypass_sel ? clk_ref : div_level;
        clk_out = pre_inv ^ invert;
    end
endmodule

// File: rtl/clkdiv_prog.sv
`timescale 1ns/1ps
module clkdiv_prog #(
    parameter int CODE_W = 5,
    localparam int CFG_W   = CODE_W + 3,
    localparam int RATIO_W = CODE_W + 1
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_byte,
    output logic             clk_out
);
    logic               divide_req;
    logic [RATIO_W-1:0] ratio_req;
    logic               invert;
    logic               div_level;
    logic               bypass_sel;

    clkdiv_cfg_decode #(.CODE_W(CODE_W)) u_decode (
        .cfg_byte   (cfg_byte),
        .divide_req (divide_req),
        .ratio_req  (ratio_req),
        .invert     (invert)
    );

    clkdiv_phase_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .divide_req (divide_req),
        .ratio_req  (ratio_req),
        .div_level  (div_level),
        .bypass_sel (bypass_sel)
    );

    clkdiv_out_mux u_mux (
        .clk_ref    (clk_ref),
        .div_level  (div_level),
        .bypass_sel (bypass_sel),
        .invert     (invert),
        .clk_out    (clk_out)
    );
endmodule

// File: tb/clkdiv_prog_test.sv
`timescale 1ns/1ps
module clkdiv_prog_test;
    localparam int CLK_P = 8;

    logic       clk;
    logic       rst_n;
    logic [7:0] cfg_byte;
    logic       clk_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bit    q_val[$];
    string q_tag[$];

    // Bench-side model state: 0 start, 1 bypass, 2 divide
    int m_mode  = 0;
    int m_ratio = 2;
    int m_cnt   = 0;

    clkdiv_prog uut (
        .clk_ref  (clk),
        .rst_n    (rst_n),
        .cfg_byte (cfg_byte),
        .clk_out  (clk_out)
    );

    initial clk = 0;
    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: clk_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Model of the requirements, evaluated at each rising edge
    task automatic model_step(input logic [7:0] c);
        bit en;
        int code;
        bit div;
        bit boundary;
        en   = c[0];
        code = int'(c[5:1]);
        div  = en && (code != 0);
        boundary = (m_mode != 2) || (m_cnt == m_ratio - 1);
        if (boundary) begin
            if (div) begin
                m_mode  = 2;
                m_ratio = code + 1;
                m_cnt   = 0;
            end else begin
                m_mode = 1;
            end
        end else begin
            m_cnt++;
        end
    endtask

    // Driver: applies a byte and pushes expected levels for n cycles
    task automatic drive(input logic [7:0] c, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            if (i == 0) cfg_byte = c;
            @(posedge clk);
            model_step(c);
            begin
                bit lvl;
                bit inv;
                lvl = (m_mode == 2) && (m_cnt < m_ratio / 2);
                inv = c[6];
                q_val.push_back(inv ^ ((m_mode == 1) ? 1'b1 : lvl));
                q_tag.push_back(tag);
                q_val.push_back(inv ^ ((m_mode == 1) ? 1'b0 : lvl));
                q_tag.push_back(tag);
            end
            #(CLK_P*7/8);
        end
    endtask

    // Monitor: samples in the high and low half of each reference cycle
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q_val.size() > 0) check(clk_out, q_val.pop_front(), q_tag.pop_front());
            #(CLK_P/2);
            if (q_val.size() > 0) check(clk_out, q_val.pop_front(), q_tag.pop_front());
        end
    end

    initial begin
        #(CLK_P*20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n    = 0;
        cfg_byte = 8'h40;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check(clk_out, 1'b1, "R8 reset level with invert");
        cfg_byte = 8'h00;
        #(CLK_P/2);
        check(clk_out, 1'b0, "R8 reset level");
        @(posedge clk);
        #(CLK_P*7/8);
        rst_n = 1;

        drive(8'h00, 6,  "R4 disabled pass-through");
        drive(8'h01, 6,  "R3 code 0 pass-through");
        drive(8'h03, 8,  "R2 divide by 2");
        drive(8'h05, 9,  "R6 divide by 3 duty");
        drive(8'h3F, 70, "R2 divide by 32");
        drive(8'h07, 6,  "R7 divide by 4 before change");
        drive(8'h09, 22, "R7 change to divide by 5 at wrap");
        drive(8'h47, 12, "R5 inverted divide by 4");
        drive(8'h87, 12, "R9 top bit ignored");
        drive(8'h06, 10, "R4 enable cleared with code");
        drive(8'h40, 6,  "R5 inverted pass-through");
        drive(8'h0B, 18, "R1 field decode divide by 6");
        drive(8'h0B, 3,  "R6 divide by 6 duty");

        // Reset mid-run: divided level forced low
        rst_n = 0;
        cfg_byte = 8'h0B;
        #(CLK_P/2);
        check(clk_out, 1'b0, "R8 reset mid-run");
        m_mode = 0;
        repeat (2) @(posedge clk);
        #(CLK_P*7/8);
        rst_n = 1;
        drive(8'h05, 9, "R8 first edge after reset loads");

        repeat (2) @(posedge clk);
        #(CLK_P/2);
        done = 1;
        summary();
        $finish;
    end
endmodule